// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the register bank that software sees when it talks to a serial port. It decodes a word index (the byte offset divided by four) and holds the control words, the FIFO control word, the baud modulator, the baud count, the one-millisecond reference and two status words. It also keeps a test word that reports whether the receive and transmit paths are empty. The receive FIFO, the transmit shifter and the baud generator sit outside the block. They report events through single-cycle inputs. A transmit data write leaves the block as a strobe carrying the character.

The block drives one level interrupt. That interrupt is the OR of three terms: the status-1 ready bits ANDed with control-1 enables at the same bit positions; the ageing flag when control 2 enables it; and the status-2 bits ANDed with a mask. The mask is built from control 4, whose enables share positions with their status-2 bits, plus the empty-FIFO enable in control 1. A write to control 2 with its soft-reset bit at zero returns the unit to its reset state. The stored soft-reset bit then reads back as one.

A request is one cycle with `req_valid_i` high. Read data and the receive-pop strobe appear in the cycle after the request. Every state change is visible at the ports one cycle after the request or event that causes it.

Top module: `uart_regbank`

## Requirements
- R1: After reset the block reads: status 1 = 0x6040 (transmit-ready bit 13, receiver-idle bit 6, RTS-state bit 14); status 2 = 0x4028 (TX-FIFO-empty bit 14, DCD-in bit 5, transmit-complete bit 3); test = 0x0060 (RX-empty bit 5, TX-empty bit 6); control 1 = 0; control 2 = 0x0001; control 3 = 0x0700; baud count = 4. In the same state, read data, the transmit strobe and the interrupt are low.
- R2: Writes to control 1 (index 0x20), control 2 (0x21), control 3 (0x22), control 4 (0x23), FIFO control (0x24), modulator (0x2A) and one-ms (0x2C) store only the low 16 bits of the write data. A read of the same index returns them zero-extended, one cycle after the read request.
- R3: A write to the increment index 0x29 stores its low 16 bits as the baud count, which reads back at index 0x2B. A read of index 0x29 returns zero.
- R4: A read of an unmapped index returns zero, and a write to it changes nothing. A write to the test register (0x2D) is ignored.
- R5: A write to status 1 (0x25) clears only the ageing bit 8, and only where the write data holds a one. A write to status 2 (0x26) clears only wake (bit 7), break (bit 2) and overrun (bit 1), each where a one is written. All other status bits keep their values.
- R6: A control-2 write with bit 0 at zero restores the reset values of both status words, the test word, control 1, control 3, the modulator and the baud count. Control 2 takes the written low 16 bits with bit 0 forced to one. Control 4, FIFO control and one-ms keep their values.
- R7: A write to index 0x10 while control-2 bit 2 (transmit enable) is set pulses `tx_strobe_o` for one cycle with the low 8 data bits on `tx_char_o`. It also clears transmit-ready and transmit-complete, which `tx_done_i` sets again. With transmit enable clear, the write produces no strobe and changes no status.
- R8: The interrupt is high when status-1 bit 13 or bit 9 (receive-ready, which follows `rx_thresh_i` one cycle late) is set together with the same bit of control 1.
- R9: The interrupt is high when the ageing bit (status 1, bit 8, set by `age_evt_i`) is set and control-2 bit 3 is set. It is not raised by the ageing bit alone.
- R10: The interrupt is high when status-2 bit 14 is set with control-1 bit 6. It is also high when any of status-2 bits 7, 3, 1 or 0 is set together with the same bit of control 4. `ovr_evt_i` sets overrun bit 1.
- R11: `rx_char_i` sets wake (bit 7) and data-ready (bit 0) in status 2 and clears RX-empty in the test word. When `rx_brk_i` is also high, it sets break (bit 2) as well. `rx_drained_i` clears data-ready and sets RX-empty.
- R12: A read of index 0x00 returns `rx_data_i` zero-extended and pulses `rx_pop_o` for one cycle, aligned with the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Register access request, one cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_index_i | input | 6 | Word index (byte offset >> 2) |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| rx_data_i | input | 16 | Head word of the external receive FIFO |
| rx_pop_o | output | 1 | Pop strobe for the receive FIFO |
| rx_char_i | input | 1 | A character entered the receive FIFO |
| rx_brk_i | input | 1 | The entering character is a break |
| rx_drained_i | input | 1 | The receive FIFO became empty |
| rx_thresh_i | input | 1 | Receive FIFO at or above its trigger level |
| age_evt_i | input | 1 | Receive ageing timeout expired |
| ovr_evt_i | input | 1 | Receive FIFO overrun |
| tx_done_i | input | 1 | Transmitter finished the last character |
| tx_strobe_o | output | 1 | Transmit character strobe |
| tx_char_o | output | 8 | Transmit character |
| irq_o | output | 1 | Level interrupt |

## Verification
A vector table drives each configuration index with upper-half junk and reads it back. This separates correct 16-bit truncation from address aliasing, and it covers increment-versus-count redirection and unmapped or ignored indices. Directed sequences then turn on one interrupt source at a time, first with its enable clear and then set. This shows that each enable gates only its own status bit, and that a status bit held by hardware (data-ready, transmit-ready) survives an all-ones clear write. The soft-reset sequence first loads non-reset values everywhere, so it can tell restored registers from retained ones (control 4, FIFO control).

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam int IDX_W = 6;
  localparam int REG_W = 16;

  typedef enum logic [3:0] {
    SL_RXD, SL_TXD, SL_CTL1, SL_CTL2, SL_CTL3, SL_CTL4, SL_FCR,
    SL_ST1, SL_ST2, SL_INC, SL_MOD, SL_CNT, SL_MS, SL_TST
  } slot_e;
  localparam int N_SLOT = 14;

  // word index of each slot; order follows slot_e
  function automatic logic [IDX_W-1:0] slot_index(input int s);
    logic [IDX_W-1:0] r;
    case (s)
      0:  r = 6'h00;
      1:  r = 6'h10;
      2:  r = 6'h20;
      3:  r = 6'h21;
      4:  r = 6'h22;
      5:  r = 6'h23;
      6:  r = 6'h24;
      7:  r = 6'h25;
      8:  r = 6'h26;
      9:  r = 6'h29;
      10: r = 6'h2A;
      11: r = 6'h2B;
      12: r = 6'h2C;
      default: r = 6'h2D;
    endcase
    return r;
  endfunction

  // status 1 bits (ready bits line up with control 1 enables)
  localparam int S1_RTSS = 14;
  localparam int S1_TRDY = 13;
  localparam int S1_RRDY = 9;
  localparam int S1_AGE  = 8;
  localparam int S1_RXDS = 6;
  // control 1 / control 2
  localparam int C1_TXMPTY = 6;
  localparam int C2_SRST   = 0;
  localparam int C2_TXEN   = 2;
  localparam int C2_AGEEN  = 3;
  // status 2 bits (low group lines up with control 4 enables)
  localparam int S2_TXFE  = 14;
  localparam int S2_WAKE  = 7;
  localparam int S2_DCDIN = 5;
  localparam int S2_TXDC  = 3;
  localparam int S2_BRCD  = 2;
  localparam int S2_ORE   = 1;
  localparam int S2_RDR   = 0;
  // test word
  localparam int T_TXE = 6;
  localparam int T_RXE = 5;

  localparam logic [REG_W-1:0] ST1_RST  = REG_W'((1 << S1_TRDY) | (1 << S1_RXDS) | (1 << S1_RTSS));
  localparam logic [REG_W-1:0] ST2_RST  = REG_W'((1 << S2_TXFE) | (1 << S2_TXDC) | (1 << S2_DCDIN));
  localparam logic [REG_W-1:0] TST_RST  = REG_W'((1 << T_RXE) | (1 << T_TXE));
  localparam logic [REG_W-1:0] CTL2_RST = REG_W'(1 << C2_SRST);
  localparam logic [REG_W-1:0] CTL3_RST = 16'h0700;
  localparam logic [REG_W-1:0] CNT_RST  = 16'h0004;

  localparam logic [REG_W-1:0] ST1_W1C  = REG_W'(1 << S1_AGE);
  localparam logic [REG_W-1:0] ST2_W1C  = REG_W'((1 << S2_WAKE) | (1 << S2_BRCD) | (1 << S2_ORE));
  localparam logic [REG_W-1:0] S1_IRQ_M = REG_W'((1 << S1_TRDY) | (1 << S1_RRDY));
  localparam logic [REG_W-1:0] C4_IRQ_M = REG_W'((1 << S2_WAKE) | (1 << S2_TXDC) | (1 << S2_ORE) | (1 << S2_RDR));

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  output logic [N_SLOT-1:0] hit_o
);
  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    assign hit_o[g] = (idx_i == slot_index(g));
  end
endmodule

// File: rtl/uart_regbank_status.sv
module uart_regbank_status
  import uart_regbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  input  logic             tx_go_i,
  input  logic             tx_done_i,
  input  logic             rx_char_i,
  input  logic             rx_brk_i,
  input  logic             rx_drained_i,
  input  logic             rx_thresh_i,
  input  logic             age_evt_i,
  input  logic             ovr_evt_i,
  input  logic [REG_W-1:0] st1_clr_i,
  input  logic [REG_W-1:0] st2_clr_i,
  output logic [REG_W-1:0] st1_o,
  output logic [REG_W-1:0] st2_o,
  output logic [REG_W-1:0] tst_o
);
  logic [REG_W-1:0] st1_q, st2_q, tst_q;
  logic [REG_W-1:0] st1_d, st2_d, tst_d;
  logic             upd_en;

  always_comb begin
    st1_d = st1_q & ~(st1_clr_i & ST1_W1C);
    st2_d = st2_q & ~(st2_clr_i & ST2_W1C);
    tst_d = tst_q;
    st1_d[S1_RRDY] = rx_thresh_i;
    if (age_evt_i) st1_d[S1_AGE] = 1'b1;
    if (tx_done_i) begin
      st1_d[S1_TRDY] = 1'b1;
      st2_d[S2_TXDC] = 1'b1;
    end
    if (tx_go_i) begin
      st1_d[S1_TRDY] = 1'b0;
      st2_d[S2_TXDC] = 1'b0;
    end
    if (ovr_evt_i) st2_d[S2_ORE] = 1'b1;
    if (rx_drained_i) begin
      st2_d[S2_RDR] = 1'b0;
      tst_d[T_RXE]  = 1'b1;
    end
    if (rx_char_i) begin
      st2_d[S2_WAKE] = 1'b1;
      st2_d[S2_RDR]  = 1'b1;
      tst_d[T_RXE]   = 1'b0;
      if (rx_brk_i) st2_d[S2_BRCD] = 1'b1;
    end
    if (soft_rst_i) begin
      st1_d = ST1_RST;
      st2_d = ST2_RST;
      tst_d = TST_RST;
    end
  end

  assign upd_en = soft_rst_i | tx_go_i | tx_done_i | rx_char_i | rx_drained_i |
                  age_evt_i | ovr_evt_i | (|st1_clr_i) | (|st2_clr_i) |
                  (rx_thresh_i != st1_q[S1_RRDY]);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= ST1_RST;
      st2_q <= ST2_RST;
      tst_q <= TST_RST;
    end else if (upd_en) begin
      st1_q <= st1_d;
      st2_q <= st2_d;
      tst_q <= tst_d;
    end
  end

  assign st1_o = st1_q;
  assign st2_o = st2_q;
  assign tst_o = tst_q;
endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq
  import uart_regbank_pkg::*;
(
  input  logic [REG_W-1:0] st1_i,
  input  logic [REG_W-1:0] st2_i,
  input  logic [REG_W-1:0] ctl1_i,
  input  logic [REG_W-1:0] ctl2_i,
  input  logic [REG_W-1:0] ctl4_i,
  output logic             irq_o
);
  logic [REG_W-1:0] st2_mask;
  logic             src_rdy, src_age, src_st2;

  always_comb begin
    st2_mask = ctl4_i & C4_IRQ_M;
    if (ctl1_i[C1_TXMPTY]) st2_mask[S2_TXFE] = 1'b1;
  end

  assign src_rdy = |(st1_i & ctl1_i & S1_IRQ_M);
  assign src_age = ctl2_i[C2_AGEEN] & st1_i[S1_AGE];
  assign src_st2 = |(st2_i & st2_mask);
  assign irq_o   = src_rdy | src_age | src_st2;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RX_W   = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [IDX_W-1:0]  req_index_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [RX_W-1:0]   rx_data_i,
  output logic              rx_pop_o,
  input  logic              rx_char_i,
  input  logic              rx_brk_i,
  input  logic              rx_drained_i,
  input  logic              rx_thresh_i,
  input  logic              age_evt_i,
  input  logic              ovr_evt_i,
  input  logic              tx_done_i,
  output logic              tx_strobe_o,
  output logic [CHAR_W-1:0] tx_char_o,
  output logic              irq_o
);
  localparam int HI_W = DATA_W - REG_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [N_SLOT-1:0] hit;
  uart_regbank_decode u_decode (.idx_i(req_index_i), .hit_o(hit));

  logic             wr, rd, soft_rst, tx_go, rd_pop;
  logic [REG_W-1:0] wlow;
  logic             unused_hi;
  assign wr        = req_valid_i & req_write_i;
  assign rd        = req_valid_i & ~req_write_i;
  assign wlow      = req_wdata_i[REG_W-1:0];
  assign unused_hi = ^req_wdata_i[DATA_W-1:DATA_W-HI_W];
  assign soft_rst  = wr & hit[SL_CTL2] & ~wlow[C2_SRST];

  // control words
  logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, fcr_q, mod_q, cnt_q, ms_q;
  logic [REG_W-1:0] ctl1_d, ctl2_d, ctl3_d, ctl4_d, fcr_d, mod_d, cnt_d, ms_d;
  logic             ctl_en;

  assign tx_go  = wr & hit[SL_TXD] & ctl2_q[C2_TXEN];
  assign rd_pop = rd & hit[SL_RXD];
  assign ctl_en = wr;

  always_comb begin
    ctl1_d = ctl1_q; ctl2_d = ctl2_q; ctl3_d = ctl3_q; ctl4_d = ctl4_q;
    fcr_d  = fcr_q;  mod_d  = mod_q;  cnt_d  = cnt_q;  ms_d   = ms_q;
    if (soft_rst) begin
      ctl1_d = '0;
      ctl3_d = CTL3_RST;
      mod_d  = '0;
      cnt_d  = CNT_RST;
    end
    if (wr) begin
      if (hit[SL_CTL1]) ctl1_d = wlow;
      if (hit[SL_CTL2]) ctl2_d = wlow | CTL2_RST;
      if (hit[SL_CTL3]) ctl3_d = wlow;
      if (hit[SL_CTL4]) ctl4_d = wlow;
      if (hit[SL_FCR])  fcr_d  = wlow;
      if (hit[SL_INC])  cnt_d  = wlow;
      if (hit[SL_MOD])  mod_d  = wlow;
      if (hit[SL_MS])   ms_d   = wlow;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= '0;
      ctl2_q <= CTL2_RST;
      ctl3_q <= CTL3_RST;
      ctl4_q <= '0;
      fcr_q  <= '0;
      mod_q  <= '0;
      cnt_q  <= CNT_RST;
      ms_q   <= '0;
    end else if (ctl_en) begin
      ctl1_q <= ctl1_d;
      ctl2_q <= ctl2_d;
      ctl3_q <= ctl3_d;
      ctl4_q <= ctl4_d;
      fcr_q  <= fcr_d;
      mod_q  <= mod_d;
      cnt_q  <= cnt_d;
      ms_q   <= ms_d;
    end
  end

  // status words
  logic [REG_W-1:0] st1_q, st2_q, tst_q, st1_clr, st2_clr;
  assign st1_clr = (wr & hit[SL_ST1]) ? wlow : '0;
  assign st2_clr = (wr & hit[SL_ST2]) ? wlow : '0;

  uart_regbank_status u_status (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .soft_rst_i  (soft_rst),
    .tx_go_i     (tx_go),
    .tx_done_i   (tx_done_i),
    .rx_char_i   (rx_char_i),
    .rx_brk_i    (rx_brk_i),
    .rx_drained_i(rx_drained_i),
    .rx_thresh_i (rx_thresh_i),
    .age_evt_i   (age_evt_i),
    .ovr_evt_i   (ovr_evt_i),
    .st1_clr_i   (st1_clr),
    .st2_clr_i   (st2_clr),
    .st1_o       (st1_q),
    .st2_o       (st2_q),
    .tst_o       (tst_q)
  );

  uart_regbank_irq u_irq (
    .st1_i (st1_q),
    .st2_i (st2_q),
    .ctl1_i(ctl1_q),
    .ctl2_i(ctl2_q),
    .ctl4_i(ctl4_q),
    .irq_o (irq_o)
  );

  // read path
  logic [DATA_W-1:0] rdata_d, rdata_q;
  always_comb begin
    rdata_d = '0;
    if (hit[SL_RXD])  rdata_d = DATA_W'(rx_data_i);
    if (hit[SL_CTL1]) rdata_d = DATA_W'(ctl1_q);
    if (hit[SL_CTL2]) rdata_d = DATA_W'(ctl2_q);
    if (hit[SL_CTL3]) rdata_d = DATA_W'(ctl3_q);
    if (hit[SL_CTL4]) rdata_d = DATA_W'(ctl4_q);
    if (hit[SL_FCR])  rdata_d = DATA_W'(fcr_q);
    if (hit[SL_ST1])  rdata_d = DATA_W'(st1_q);
    if (hit[SL_ST2])  rdata_d = DATA_W'(st2_q);
    if (hit[SL_MOD])  rdata_d = DATA_W'(mod_q);
    if (hit[SL_CNT])  rdata_d = DATA_W'(cnt_q);
    if (hit[SL_MS])   rdata_d = DATA_W'(ms_q);
    if (hit[SL_TST])  rdata_d = DATA_W'(tst_q);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  // strobes to the neighbours
  logic              tx_strobe_q, rx_pop_q;
  logic [CHAR_W-1:0] tx_char_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tx_strobe_q <= 1'b0;
      rx_pop_q    <= 1'b0;
    end else begin
      tx_strobe_q <= tx_go;
      rx_pop_q    <= rd_pop;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     tx_char_q <= '0;
    else if (tx_go) tx_char_q <= req_wdata_i[CHAR_W-1:0];
  end

  assign rdata_o     = rdata_q;
  assign tx_strobe_o = tx_strobe_q;
  assign tx_char_o   = tx_char_q;
  assign rx_pop_o    = rx_pop_q;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_regbank_pkg::*;
(
  input logic             clk_i,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [IDX_W-1:0] req_index_i,
  input logic [31:0]      rdata_o,
  input logic             rx_pop_o,
  input logic             rx_char_i,
  input logic             tx_strobe_o,
  input logic             irq_o,
  input logic [REG_W-1:0] st1_q,
  input logic [REG_W-1:0] st2_q,
  input logic [REG_W-1:0] ctl1_q,
  input logic [REG_W-1:0] ctl2_q,
  input logic [REG_W-1:0] ctl4_q
);
  // R7: a strobe only follows a transmit-data write
  a_r7_strobe_from_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_strobe_o |-> $past(req_valid_i && req_write_i && req_index_i == 6'h10));

  // R7: an accepted transmit write drops transmit-ready
  a_r7_trdy_drop: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_index_i == 6'h10 && ctl2_q[C2_TXEN])
      |=> !st1_q[S1_TRDY]);

  // R12: pop only after a receive-data read
  a_r12_pop_from_read: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_pop_o |-> $past(req_valid_i && !req_write_i && req_index_i == 6'h00));

  // R11: an incoming character leaves wake set
  a_r11_wake_set: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_char_i && !req_valid_i) |=> st2_q[S2_WAKE]);

  // R4: unmapped indices above the map read zero
  a_r4_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && !req_write_i && req_index_i > 6'h2D) |=> rdata_o == 32'h0);

  // R8, R9, R10: no enable set means no interrupt
  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((ctl1_q & (S1_IRQ_M | REG_W'(1 << C1_TXMPTY))) == '0 &&
     (ctl4_q & C4_IRQ_M) == '0 && !ctl2_q[C2_AGEEN]) |-> !irq_o);
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_index_i(req_index_i),
  .rdata_o    (rdata_o),
  .rx_pop_o   (rx_pop_o),
  .rx_char_i  (rx_char_i),
  .tx_strobe_o(tx_strobe_o),
  .irq_o      (irq_o),
  .st1_q      (st1_q),
  .st2_q      (st2_q),
  .ctl1_q     (ctl1_q),
  .ctl2_q     (ctl2_q),
  .ctl4_q     (ctl4_q)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {write index, write data, read index, expected}
  localparam logic [75:0] VEC [NVEC] = '{
    {6'h21, 32'hFFFF0005, 6'h21, 32'h00000005},
    {6'h22, 32'h1234ABCD, 6'h22, 32'h0000ABCD},
    {6'h23, 32'h55550000, 6'h23, 32'h00000000},
    {6'h24, 32'hDEAD0021, 6'h24, 32'h00000021},
    {6'h2A, 32'h0001BEEF, 6'h2A, 32'h0000BEEF},
    {6'h2C, 32'h00004321, 6'h2C, 32'h00004321},
    {6'h29, 32'h00007777, 6'h2B, 32'h00007777},
    {6'h2D, 32'h0000FFFF, 6'h2D, 32'h00000060},
    {6'h30, 32'h0000FFFF, 6'h30, 32'h00000000},
    {6'h20, 32'hFFFF0000, 6'h20, 32'h00000000},
    {6'h29, 32'h00007777, 6'h29, 32'h00000000}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic [5:0]  req_index = '0;
  logic [31:0] req_wdata = '0, rdata;
  logic [15:0] rx_data = '0;
  logic        rx_pop, rx_char = 0, rx_brk = 0, rx_drained = 0, rx_thresh = 0;
  logic        age_evt = 0, ovr_evt = 0, tx_done = 0, tx_strobe, irq;
  logic [7:0]  tx_char;
  int          n_chk = 0, n_fail = 0, n_strobe = 0, n_pop = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank u_uart_regbank (
    .clk_i(clk), .rst_n_i(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_index_i(req_index), .req_wdata_i(req_wdata), .rdata_o(rdata),
    .rx_data_i(rx_data), .rx_pop_o(rx_pop), .rx_char_i(rx_char), .rx_brk_i(rx_brk),
    .rx_drained_i(rx_drained), .rx_thresh_i(rx_thresh), .age_evt_i(age_evt),
    .ovr_evt_i(ovr_evt), .tx_done_i(tx_done), .tx_strobe_o(tx_strobe),
    .tx_char_o(tx_char), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (tx_strobe) n_strobe++;
    if (rx_pop) n_pop++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_index = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [5:0] idx, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_index = idx;
    @(negedge clk);
    req_valid = 0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_rx(input logic brk);
    @(negedge clk); rx_char = 1; rx_brk = brk;
    @(negedge clk); rx_char = 0; rx_brk = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int s0, p0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 strobe", {31'b0, tx_strobe}, 0);
    chk("R1 rdata", rdata, 0);
    rd_chk("R1 status1", 6'h25, 32'h6040);
    rd_chk("R1 status2", 6'h26, 32'h4028);
    rd_chk("R1 test", 6'h2D, 32'h0060);
    rd_chk("R1 ctl1", 6'h20, 32'h0);
    rd_chk("R1 ctl2", 6'h21, 32'h0001);
    rd_chk("R1 ctl3", 6'h22, 32'h0700);
    rd_chk("R1 count", 6'h2B, 32'h0004);

    // R2 R3 R4 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][75:70], VEC[i][69:38]);
      rd_chk($sformatf("R2/R3/R4 vec%0d", i), VEC[i][37:32], VEC[i][31:0]);
    end

    // R7 transmit gating
    s0 = n_strobe;
    wr(6'h10, 32'h00000141);
    chk("R7 strobe", {31'b0, tx_strobe}, 1);
    chk("R7 char", {24'b0, tx_char}, 32'h41);
    rd_chk("R7 trdy low", 6'h25, 32'h4040);
    rd_chk("R7 txdc low", 6'h26, 32'h4020);
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    rd_chk("R7 trdy back", 6'h25, 32'h6040);
    wr(6'h21, 32'h0001);
    wr(6'h10, 32'h00000055);
    @(negedge clk);
    chk("R7 no strobe", n_strobe - s0, 1);
    rd_chk("R7 status kept", 6'h25, 32'h6040);

    // R8 status1 ready path
    wr(6'h20, 32'h2000);
    chk("R8 trdy irq", {31'b0, irq}, 1);
    wr(6'h20, 32'h0200);
    chk("R8 rrdy off", {31'b0, irq}, 0);
    @(negedge clk); rx_thresh = 1;
    @(negedge clk);
    chk("R8 rrdy irq", {31'b0, irq}, 1);
    rx_thresh = 0;
    @(negedge clk);
    chk("R8 rrdy gone", {31'b0, irq}, 0);
    wr(6'h20, 32'h0);

    // R9 ageing path
    @(negedge clk); age_evt = 1; @(negedge clk); age_evt = 0;
    chk("R9 gated", {31'b0, irq}, 0);
    rd_chk("R9 age flag", 6'h25, 32'h6140);
    wr(6'h21, 32'h0009);
    chk("R9 enabled", {31'b0, irq}, 1);
    wr(6'h25, 32'hFFFF);
    rd_chk("R5 only age cleared", 6'h25, 32'h6040);
    chk("R9 cleared", {31'b0, irq}, 0);
    wr(6'h21, 32'h0001);

    // R10 R11 status2 path
    wr(6'h20, 32'h0040);
    chk("R10 txfe irq", {31'b0, irq}, 1);
    wr(6'h20, 32'h0);
    chk("R10 txfe off", {31'b0, irq}, 0);
    wr(6'h23, 32'h0008);
    chk("R10 txdc irq", {31'b0, irq}, 1);
    wr(6'h23, 32'h0001);
    chk("R10 rdr idle", {31'b0, irq}, 0);
    pulse_rx(0);
    chk("R10 rdr irq", {31'b0, irq}, 1);
    rd_chk("R11 status2 char", 6'h26, 32'h40A9);
    rd_chk("R11 rx not empty", 6'h2D, 32'h0040);
    wr(6'h26, 32'hFFFF);
    rd_chk("R5 wake cleared rdr kept", 6'h26, 32'h4029);
    @(negedge clk); rx_drained = 1; @(negedge clk); rx_drained = 0;
    rd_chk("R11 drained", 6'h26, 32'h4028);
    rd_chk("R11 rx empty", 6'h2D, 32'h0060);
    chk("R10 rdr gone", {31'b0, irq}, 0);
    wr(6'h23, 32'h0002);
    @(negedge clk); ovr_evt = 1; @(negedge clk); ovr_evt = 0;
    chk("R10 ore irq", {31'b0, irq}, 1);
    wr(6'h26, 32'h0002);
    rd_chk("R5 ore cleared", 6'h26, 32'h4028);
    chk("R10 ore gone", {31'b0, irq}, 0);
    pulse_rx(1);
    rd_chk("R11 break", 6'h26, 32'h40AD);
    wr(6'h23, 32'h0080);
    chk("R10 wake irq", {31'b0, irq}, 1);
    wr(6'h26, 32'h0084);
    rd_chk("R5 wake+break cleared", 6'h26, 32'h4029);
    @(negedge clk); rx_drained = 1; @(negedge clk); rx_drained = 0;

    // R12 receive read
    rx_data = 16'h01A5;
    p0 = n_pop;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_index = 6'h00;
    @(negedge clk);
    req_valid = 0;
    chk("R12 data", rdata, 32'h01A5);
    chk("R12 pop", {31'b0, rx_pop}, 1);
    @(negedge clk);
    chk("R12 single pop", n_pop - p0, 1);

    // R6 soft reset
    @(negedge clk); age_evt = 1; @(negedge clk); age_evt = 0;
    wr(6'h20, 32'h0040);
    wr(6'h21, 32'h0004);
    rd_chk("R6 ctl2 srst", 6'h21, 32'h0005);
    rd_chk("R6 ctl1", 6'h20, 32'h0);
    rd_chk("R6 ctl3", 6'h22, 32'h0700);
    rd_chk("R6 mod", 6'h2A, 32'h0);
    rd_chk("R6 count", 6'h2B, 32'h0004);
    rd_chk("R6 status1", 6'h25, 32'h6040);
    rd_chk("R6 status2", 6'h26, 32'h4028);
    rd_chk("R6 test", 6'h2D, 32'h0060);
    rd_chk("R6 ctl4 kept", 6'h23, 32'h0080);
    rd_chk("R6 fcr kept", 6'h24, 32'h0021);
    chk("R6 irq", {31'b0, irq}, 0);

    done = 1;
    summary();
  end
endmodule